// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the digital control core of a half-bridge power stage. A single three-level PWM command becomes two gate enables, one for the high-side switch and one for the low-side switch. Before it switches a gate on, the block waits for a comparator flag to confirm that the opposite gate has discharged below its threshold. The dead time therefore follows the real gate charge of the switches fitted, on top of a fixed delay counted in clock cycles.

The PWM command arrives already decoded into high, low and a mid-level shutdown window. A command that stays in the window past a hold-off turns both gates off and keeps them off until the command leaves the window. An enable input and a power-on-ready input gate both outputs at once. A status output reports the current phase of the sequence. The PWM level, both feedback flags and the enable qualifier each pass through a two-flop synchronizer, and that latency is included in every programmed delay.

Top module: `agt_gate_seq`

## Requirements
- R1: `pwm_i` encoding: 2'b00 is low, 2'b01 is high, and any code with bit 1 set is the mid window. Take the sequencer conducting low-side and a change of `pwm_i` to high. `ls_en_o` falls on exactly the `T_LS_OFF`-th rising clock edge after the change, and `hs_en_o` stays low.
- R2: While `pwm_i` is high, `hs_en_o` does not rise as long as `ls_gate_low_i` is low. Once the flag rises and stays high, `hs_en_o` rises on the `T_HS_ON`-th edge after the flag rises. Whenever `hs_en_o` rises, the flag has been high at the `min(T_HS_ON,T_EXIT)-2` consecutive edges that end two edges earlier.
- R3: Take the sequencer conducting high-side and a change of `pwm_i` to low. `hs_en_o` falls on the `T_HS_OFF`-th edge after the change.
- R4: The mirror of R2 for the low side. `ls_en_o` rises on the `T_LS_ON`-th edge after `hs_gate_low_i` rises, and every rise of `ls_en_o` is preceded by `min(T_LS_ON,T_EXIT)-2` consecutive sampled edges of that flag high.
- R5: `hs_en_o` and `ls_en_o` are never high in the same cycle.
- R6: If `pwm_i` enters the mid window from a conducting state, the conducting gate falls on the `T_HOLD`-th edge. Both gates then stay low, and `state_o` reads shutdown while the command stays in the window.
- R7: A mid-window excursion that returns to the same level before the hold-off expires leaves the conducting gate on without a break.
- R8: From shutdown, moving to high with `ls_gate_low_i` set raises `hs_en_o` on the `T_EXIT`-th edge. Moving to low with `hs_gate_low_i` set raises `ls_en_o` on the `T_EXIT`-th edge.
- R9: A PWM change that arrives during a pending turn-on delay cancels that turn-on. The gate being delayed never rises, and sequencing restarts toward the new level.
- R10: When `en_i` or `por_ok_i` is low, both gate enables are low in the same cycle. `state_o` reads idle by the third edge.
- R11: `state_o` codes: 0 idle, 1 low-side on, 2 transition, 3 high-side on, 4 shutdown. Reset gives idle with both gates low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver enable |
| por_ok_i | input | 1 | Supply ready after power-on reset |
| pwm_i | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid window |
| ls_gate_low_i | input | 1 | Low-side gate has fallen below its threshold |
| hs_gate_low_i | input | 1 | High-side gate-to-phase voltage has fallen below its threshold |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Sequence status code |

## Verification
Every gate change counts from the input change that caused it. Two synchronizer flops and the state register account for three edges, and the delay counter supplies the rest. A PWM change or flag change therefore shows on the outputs exactly at the edge given by the matching `T_*` parameter. Disabling is the exception: it acts in the same cycle, through combinational masking, while `state_o` follows three edges later. The directed checks sample after every edge of a delay window, so one edge early or late is flagged. The random phase drives a gate-discharge model with a variable lag and compares each gate rise with the history of the opposite flag, two edges behind the rise.

// File: rtl/agt_pkg.sv
package agt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LS_ON,
    ST_LS_OFFD,
    ST_WAIT_LS,
    ST_HS_OND,
    ST_HS_ON,
    ST_HS_OFFD,
    ST_WAIT_HS,
    ST_LS_OND,
    ST_SDH_LS,
    ST_SDH_HS,
    ST_SHUT,
    ST_EXIT_HS,
    ST_EXIT_LS
  } seq_state_e;

  typedef enum logic [2:0] {
    STAT_IDLE    = 3'd0,
    STAT_LOW_ON  = 3'd1,
    STAT_TRANS   = 3'd2,
    STAT_HIGH_ON = 3'd3,
    STAT_SHUT    = 3'd4
  } seq_stat_e;

  localparam logic [1:0] PWM_LO = 2'b00;
  localparam logic [1:0] PWM_HI = 2'b01;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/agt_sync.sv
module agt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[g] <= '0;
      else if (g == 0) stg[g] <= d_i;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/agt_delay.sv
module agt_delay #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // a freshly loaded count must never wrap upward
  assert_cnt_monotone_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/agt_fsm.sv
module agt_fsm
  import agt_pkg::*;
#(
  parameter int CW       = 2,
  parameter int D_LS_OFF = 2,
  parameter int D_HS_ON  = 1,
  parameter int D_HS_OFF = 1,
  parameter int D_LS_ON  = 3,
  parameter int D_HOLD   = 1,
  parameter int D_EXIT   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [1:0]    pwm_i,
  input  logic          lo_low_i,
  input  logic          hi_low_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [CW-1:0] val_o,
  output logic          hs_o,
  output logic          ls_o,
  output logic [2:0]    stat_o
);

  localparam logic [CW-1:0] V_LS_OFF = CW'(D_LS_OFF - 1);
  localparam logic [CW-1:0] V_HS_ON  = CW'(D_HS_ON - 1);
  localparam logic [CW-1:0] V_HS_OFF = CW'(D_HS_OFF - 1);
  localparam logic [CW-1:0] V_LS_ON  = CW'(D_LS_ON - 1);
  localparam logic [CW-1:0] V_HOLD   = CW'(D_HOLD - 1);
  localparam logic [CW-1:0] V_EXIT   = CW'(D_EXIT - 1);

  seq_state_e st_q, nxt;
  seq_stat_e  stat;
  logic p_hi, p_lo, p_mid;

  assign p_hi  = (pwm_i == PWM_HI);
  assign p_lo  = (pwm_i == PWM_LO);
  assign p_mid = pwm_i[1];

  always_comb begin
    nxt    = st_q;
    load_o = 1'b0;
    val_o  = '0;
    if (!run_i) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (p_hi)      nxt = ST_WAIT_LS;
          else if (p_lo) nxt = ST_WAIT_HS;
          else           nxt = ST_SHUT;
        end
        ST_LS_ON: begin
          if (p_hi)       begin nxt = ST_LS_OFFD; load_o = 1'b1; val_o = V_LS_OFF; end
          else if (p_mid) begin nxt = ST_SDH_LS;  load_o = 1'b1; val_o = V_HOLD;   end
        end
        ST_HS_ON: begin
          if (p_lo)       begin nxt = ST_HS_OFFD; load_o = 1'b1; val_o = V_HS_OFF; end
          else if (p_mid) begin nxt = ST_SDH_HS;  load_o = 1'b1; val_o = V_HOLD;   end
        end
        ST_LS_OFFD: begin
          if (p_lo)        nxt = ST_LS_ON;
          else if (p_mid)  begin nxt = ST_SDH_LS; load_o = 1'b1; val_o = V_HOLD; end
          else if (done_i) nxt = ST_WAIT_LS;
        end
        ST_HS_OFFD: begin
          if (p_hi)        nxt = ST_HS_ON;
          else if (p_mid)  begin nxt = ST_SDH_HS; load_o = 1'b1; val_o = V_HOLD; end
          else if (done_i) nxt = ST_WAIT_HS;
        end
        ST_WAIT_LS: begin
          if (p_lo)          nxt = ST_WAIT_HS;
          else if (p_mid)    nxt = ST_SHUT;
          else if (lo_low_i) begin nxt = ST_HS_OND; load_o = 1'b1; val_o = V_HS_ON; end
        end
        ST_WAIT_HS: begin
          if (p_hi)          nxt = ST_WAIT_LS;
          else if (p_mid)    nxt = ST_SHUT;
          else if (hi_low_i) begin nxt = ST_LS_OND; load_o = 1'b1; val_o = V_LS_ON; end
        end
        ST_HS_OND: begin
          if (p_lo)           nxt = ST_WAIT_HS;
          else if (p_mid)     nxt = ST_SHUT;
          else if (!lo_low_i) nxt = ST_WAIT_LS;
          else if (done_i)    nxt = ST_HS_ON;
        end
        ST_LS_OND: begin
          if (p_hi)           nxt = ST_WAIT_LS;
          else if (p_mid)     nxt = ST_SHUT;
          else if (!hi_low_i) nxt = ST_WAIT_HS;
          else if (done_i)    nxt = ST_LS_ON;
        end
        ST_SDH_LS: begin
          if (p_lo)        nxt = ST_LS_ON;
          else if (p_hi)   begin nxt = ST_LS_OFFD; load_o = 1'b1; val_o = V_LS_OFF; end
          else if (done_i) nxt = ST_SHUT;
        end
        ST_SDH_HS: begin
          if (p_hi)        nxt = ST_HS_ON;
          else if (p_lo)   begin nxt = ST_HS_OFFD; load_o = 1'b1; val_o = V_HS_OFF; end
          else if (done_i) nxt = ST_SHUT;
        end
        ST_SHUT: begin
          if (p_hi) begin
            if (lo_low_i) begin nxt = ST_EXIT_HS; load_o = 1'b1; val_o = V_EXIT; end
            else          nxt = ST_WAIT_LS;
          end else if (p_lo) begin
            if (hi_low_i) begin nxt = ST_EXIT_LS; load_o = 1'b1; val_o = V_EXIT; end
            else          nxt = ST_WAIT_HS;
          end
        end
        ST_EXIT_HS: begin
          if (p_lo)           nxt = ST_WAIT_HS;
          else if (p_mid)     nxt = ST_SHUT;
          else if (!lo_low_i) nxt = ST_WAIT_LS;
          else if (done_i)    nxt = ST_HS_ON;
        end
        ST_EXIT_LS: begin
          if (p_hi)           nxt = ST_WAIT_LS;
          else if (p_mid)     nxt = ST_SHUT;
          else if (!hi_low_i) nxt = ST_WAIT_HS;
          else if (done_i)    nxt = ST_LS_ON;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= nxt;
  end

  assign hs_o = (st_q == ST_HS_ON) || (st_q == ST_HS_OFFD) || (st_q == ST_SDH_HS);
  assign ls_o = (st_q == ST_LS_ON) || (st_q == ST_LS_OFFD) || (st_q == ST_SDH_LS);

  always_comb begin
    unique case (st_q)
      ST_IDLE:  stat = STAT_IDLE;
      ST_LS_ON: stat = STAT_LOW_ON;
      ST_HS_ON: stat = STAT_HIGH_ON;
      ST_SHUT:  stat = STAT_SHUT;
      default:  stat = STAT_TRANS;
    endcase
  end
  assign stat_o = stat;

  // adaptive turn-on: the opposite gate must be reported discharged
  assert_hs_needs_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> $past(lo_low_i));
  assert_ls_needs_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> $past(hi_low_i));
  assert_sd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHUT && run_i && p_mid) |=> (!hs_o && !ls_o && st_q == ST_SHUT));
  assert_stop_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!hs_o && !ls_o && stat_o == 3'd0));

endmodule

// File: rtl/agt_gate_seq.sv
module agt_gate_seq
  import agt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T_LS_OFF    = 5,
  parameter int T_HS_ON     = 4,
  parameter int T_HS_OFF    = 4,
  parameter int T_LS_ON     = 6,
  parameter int T_HOLD      = 4,
  parameter int T_EXIT      = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       por_ok_i,
  input  logic [1:0] pwm_i,
  input  logic       ls_gate_low_i,
  input  logic       hs_gate_low_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic [2:0] state_o
);

  // synchronizer plus state register latency is part of every delay
  localparam int LAT      = SYNC_STAGES + 1;
  localparam int D_LS_OFF = T_LS_OFF - LAT;
  localparam int D_HS_ON  = T_HS_ON  - LAT;
  localparam int D_HS_OFF = T_HS_OFF - LAT;
  localparam int D_LS_ON  = T_LS_ON  - LAT;
  localparam int D_HOLD   = T_HOLD   - LAT;
  localparam int D_EXIT   = T_EXIT   - LAT;
  localparam int D_MAX    = max_i(max_i(max_i(D_LS_OFF, D_HS_ON), max_i(D_HS_OFF, D_LS_ON)),
                                  max_i(D_HOLD, D_EXIT));
  localparam int CW       = (D_MAX < 2) ? 1 : $clog2(D_MAX);
  localparam int SW       = 5;

  logic [SW-1:0] raw, syn;
  logic          run_s, lo_low_s, hi_low_s;
  logic [1:0]    pwm_s;
  logic          load, done, hs_q, ls_q, live;
  logic [CW-1:0] val;

  assign raw = {en_i & por_ok_i, pwm_i, ls_gate_low_i, hs_gate_low_i};

  agt_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign run_s    = syn[4];
  assign pwm_s    = syn[3:2];
  assign lo_low_s = syn[1];
  assign hi_low_s = syn[0];

  agt_delay #(.CW(CW)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .val_i(val), .done_o(done)
  );

  agt_fsm #(
    .CW(CW), .D_LS_OFF(D_LS_OFF), .D_HS_ON(D_HS_ON), .D_HS_OFF(D_HS_OFF),
    .D_LS_ON(D_LS_ON), .D_HOLD(D_HOLD), .D_EXIT(D_EXIT)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_s), .pwm_i(pwm_s),
    .lo_low_i(lo_low_s), .hi_low_i(hi_low_s), .done_i(done),
    .load_o(load), .val_o(val), .hs_o(hs_q), .ls_o(ls_q), .stat_o(state_o)
  );

  // disable acts without synchronizer latency
  assign live    = en_i & por_ok_i;
  assign hs_en_o = hs_q & live;
  assign ls_en_o = ls_q & live;

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

endmodule

// File: tb/sim_agt_gate_seq.sv
module sim_agt_gate_seq;

  localparam int P_LS_OFF = 5;
  localparam int P_HS_ON  = 4;
  localparam int P_HS_OFF = 4;
  localparam int P_LS_ON  = 6;
  localparam int P_HOLD   = 4;
  localparam int P_EXIT   = 4;
  localparam int WIN_HS   = ((P_HS_ON < P_EXIT) ? P_HS_ON : P_EXIT) - 2;
  localparam int WIN_LS   = ((P_LS_ON < P_EXIT) ? P_LS_ON : P_EXIT) - 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, en, por_ok, lo_low, hi_low;
  logic [1:0] pwm;
  logic       hs_en, ls_en;
  logic [2:0] st;

  agt_gate_seq #(
    .SYNC_STAGES(2), .T_LS_OFF(P_LS_OFF), .T_HS_ON(P_HS_ON), .T_HS_OFF(P_HS_OFF),
    .T_LS_ON(P_LS_ON), .T_HOLD(P_HOLD), .T_EXIT(P_EXIT)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .por_ok_i(por_ok), .pwm_i(pwm),
    .ls_gate_low_i(lo_low), .hs_gate_low_i(hi_low),
    .hs_en_o(hs_en), .ls_en_o(ls_en), .state_o(st)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  ended = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic pick(input int sel);
    return (sel != 0) ? hs_en : ls_en;
  endfunction

  // gate sel moves from oldv to newv exactly at edge t
  task automatic expect_edge(input int sel, input int t, input logic oldv, input logic newv,
                             input string req);
    for (int k = 1; k <= t; k++) begin
      logic e;
      tick();
      e = (k < t) ? oldv : newv;
      chk(pick(sel) == e, req, int'(pick(sel)), int'(e));
      chk(!(hs_en && ls_en), "R5", int'(hs_en && ls_en), 0);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lo_run, hi_run, lo_r0, lo_r1, lo_r2, hi_r0, hi_r1, hi_r2;
    int kd, en_cnt;
    logic hs_prev, ls_prev;
    logic [3:0] ls_hist, hs_hist;

    rst_n = 1'b0; en = 1'b0; por_ok = 1'b0; pwm = 2'b00; lo_low = 1'b1; hi_low = 1'b1;
    repeat (3) tick();
    chk(st == 3'd0, "R11", st, 0);
    chk(!hs_en && !ls_en, "R11", int'({hs_en, ls_en}), 0);
    rst_n = 1'b1;
    en = 1'b1; por_ok = 1'b1;
    repeat (10) tick();
    chk(ls_en && !hs_en, "R11", int'({hs_en, ls_en}), 1);
    chk(st == 3'd1, "R11", st, 1);
    lo_low = 1'b0;
    tick();

    // R1: rising command removes low side after T_LS_OFF
    pwm = 2'b01;
    expect_edge(0, P_LS_OFF, 1'b1, 1'b0, "R1");
    chk(!hs_en, "R1", hs_en, 0);
    chk(st == 3'd2, "R11", st, 2);

    // R2: high side waits for the low-side flag
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!hs_en, "R2", hs_en, 0);
    end
    lo_low = 1'b1;
    expect_edge(1, P_HS_ON, 1'b0, 1'b1, "R2");
    chk(st == 3'd3, "R11", st, 3);
    hi_low = 1'b0;

    // R3 / R4: falling command
    pwm = 2'b00;
    expect_edge(1, P_HS_OFF, 1'b1, 1'b0, "R3");
    chk(!ls_en, "R3", ls_en, 0);
    for (int k = 0; k < 2; k++) begin
      tick();
      chk(!ls_en, "R4", ls_en, 0);
    end
    hi_low = 1'b1;
    expect_edge(0, P_LS_ON, 1'b0, 1'b1, "R4");
    lo_low = 1'b0;

    // R6: mid window from low-side conduction
    pwm = 2'b10;
    expect_edge(0, P_HOLD, 1'b1, 1'b0, "R6");
    chk(st == 3'd4, "R6", st, 4);
    lo_low = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(st == 3'd4 && !hs_en && !ls_en, "R6", st, 4);
    end

    // R8: exit toward high
    pwm = 2'b01;
    expect_edge(1, P_EXIT, 1'b0, 1'b1, "R8");
    hi_low = 1'b0;
    tick();

    // R7: short excursion into the window
    pwm = 2'b11;
    tick();
    pwm = 2'b01;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(hs_en, "R7", hs_en, 1);
    end

    // R9: cancel a pending low-side turn-on
    pwm = 2'b00;
    expect_edge(1, P_HS_OFF, 1'b1, 1'b0, "R3");
    hi_low = 1'b1;
    tick();
    pwm = 2'b01;
    for (int k = 0; k < 12; k++) begin
      tick();
      chk(!ls_en, "R9", ls_en, 0);
    end
    chk(hs_en, "R9", hs_en, 1);
    hi_low = 1'b0;

    // R8: exit toward low
    pwm = 2'b10;
    repeat (8) tick();
    chk(st == 3'd4 && !hs_en, "R6", st, 4);
    hi_low = 1'b1;
    repeat (4) tick();
    pwm = 2'b00;
    expect_edge(0, P_EXIT, 1'b0, 1'b1, "R8");
    lo_low = 1'b0;
    tick();

    // R10: enable and supply-ready gating
    en = 1'b0;
    #1;
    chk(!hs_en && !ls_en, "R10", int'({hs_en, ls_en}), 0);
    repeat (3) tick();
    chk(st == 3'd0, "R10", st, 0);
    lo_low = 1'b1;
    en = 1'b1;
    repeat (12) tick();
    chk(ls_en, "R10", ls_en, 1);
    lo_low = 1'b0;
    por_ok = 1'b0;
    #1;
    chk(!hs_en && !ls_en, "R10", int'({hs_en, ls_en}), 0);
    repeat (4) tick();
    chk(st == 3'd0 && !ls_en, "R10", st, 0);
    lo_low = 1'b1;
    por_ok = 1'b1;
    repeat (12) tick();
    chk(ls_en, "R10", ls_en, 1);

    // random phase with a lagging gate-discharge model
    void'($urandom(32'd1234));
    lo_run = 0; hi_run = 0;
    lo_r0 = 0; lo_r1 = 0; lo_r2 = 0; hi_r0 = 0; hi_r1 = 0; hi_r2 = 0;
    kd = 2; en_cnt = 0;
    ls_hist = '0; hs_hist = '0;
    hs_prev = hs_en; ls_prev = ls_en;
    for (int c = 0; c < 4000; c++) begin
      int r;
      tick();
      lo_run = lo_low ? lo_run + 1 : 0;
      hi_run = hi_low ? hi_run + 1 : 0;
      lo_r2 = lo_r1; lo_r1 = lo_r0; lo_r0 = lo_run;
      hi_r2 = hi_r1; hi_r1 = hi_r0; hi_r0 = hi_run;
      chk(!(hs_en && ls_en), "R5", int'({hs_en, ls_en}), 0);
      chk(st <= 3'd4, "R11", st, 4);
      if (hs_en && !hs_prev) chk(lo_r2 >= WIN_HS, "R2", lo_r2, WIN_HS);
      if (ls_en && !ls_prev) chk(hi_r2 >= WIN_LS, "R4", hi_r2, WIN_LS);
      hs_prev = hs_en;
      ls_prev = ls_en;
      if (c % 500 == 0) kd = 1 + int'($urandom % 3);
      ls_hist = {ls_hist[2:0], ls_en};
      hs_hist = {hs_hist[2:0], hs_en};
      lo_low = !ls_hist[kd-1];
      hi_low = !hs_hist[kd-1];
      if ($urandom % 100 < 8) begin
        r = int'($urandom % 10);
        pwm = (r < 4) ? 2'b00 : (r < 8) ? 2'b01 : 2'b10;
      end
      if (en && ($urandom % 200 == 0)) begin
        en = 1'b0;
        en_cnt = 1 + int'($urandom % 6);
      end else if (!en) begin
        en_cnt--;
        if (en_cnt <= 0) en = 1'b1;
      end
    end
    finish_run();
  end

endmodule